// File: doc/BRIEF.md
# Streaming Top-Three and Mean Unit

This block watches a burst of unsigned samples and reports two kinds of summary about it: the three largest values in the burst, ranked, and the mean of the burst. A run starts with a one-cycle `start` pulse. From the following clock edge the block takes one sample per clock, for exactly K = 2^LOG_K samples. It then raises `finished` and holds the results until the next run.

The ranked list is held in three registers that stay in descending order. Each new sample is compared against all three at once. A sample that beats a slot pushes that slot and every slot below it down by one place. A running sum, LOG_K bits wider than a sample, is kept alongside the list. The mean is the sum shifted right by LOG_K bits.

A 2-bit selector chooses which of the four results appears on the registered output. A controller FSM drives the slot enables, the shift selects and the accumulator from the comparator results. The datapath holds the registers, comparators, adder and counter.

Top module: `rank3_mean`

## Requirements
- R1: While `rst` is high and after it falls, `finished` is 0 and `result` is 0 until a run completes.
- R2: A `start` taken while idle or finished clears all three ranked slots, the sum and the sample counter to zero. Samples are then consumed on each of the next K rising edges, starting with the edge after the one that saw `start`.
- R3: A sample strictly greater than the largest slot moves the second slot to the third, the largest to the second, and loads the sample into the largest. Selector code 11 shows the largest value.
- R4: Otherwise, a sample strictly greater than the second slot moves the second slot to the third and loads the sample into the second. Selector code 10 shows the second-largest value.
- R5: Otherwise, a sample strictly greater than the third slot loads into the third. Selector code 01 shows the third-largest value.
- R6: A sample not strictly greater than any slot changes no slot, and a sample equal to a stored value does not displace it.
- R7: The sum is DATA_W+LOG_K bits wide and never wraps. A run of all-maximum samples yields a mean equal to the maximum sample value.
- R8: Selector code 00 shows the mean: the sum of the K samples shifted right by LOG_K bits, truncated toward zero.
- R9: `result` is registered. It shows the value chosen by `sel_mode` one clock edge after `sel_mode` changes.
- R10: `finished` rises on the edge after the one that consumed the last sample. It stays high until a `start` is sampled, which clears it on that same edge.
- R11: A `start` pulse that arrives while samples are still being consumed is ignored. The run continues and produces the same results it would have produced without the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| sample | input | DATA_W | Unsigned input sample, consumed once per clock during a run |
| sel_mode | input | 2 | Result select: 00 mean, 01 third-largest, 10 second-largest, 11 largest |
| result | output | DATA_W | Registered selected result |
| finished | output | 1 | High from the edge after the last sample until the next start |

## Verification
Label the edge that takes `start` E0. The last sample is then consumed at edge EK, and both `finished` and the final `result` appear after edge EK+1. Any later change of `sel_mode` shows on `result` one edge after the change. The bench drives every input on the falling edge and samples on the next falling edge. It checks that `finished` is still low half a cycle after EK, and checks `finished` and the mean half a cycle after EK+1. Each of the three ranked values is then read one full cycle after its selector code is applied. With DATA_W=3 and LOG_K=2, the bench runs all 4096 four-sample sequences through this schedule. It compares each result against a sorted list and a shifted sum that it computes itself.

// File: rtl/rank3_mean_pkg.sv
package rank3_mean_pkg;
  localparam int RANKS = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } run_state_t;

  localparam logic [1:0] SEL_MEAN = 2'b00;
endpackage

// File: rtl/rank3_list.sv
module rank3_list
  import rank3_mean_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic [DATA_W-1:0]             sample,
  input  logic [RANKS-1:0]              slot_en,
  input  logic [RANKS-1:0]              shift_sel,
  output logic [RANKS-1:0]              beats,
  output logic [RANKS-1:0][DATA_W-1:0]  ranks
);
  logic [RANKS-1:0][DATA_W-1:0] slot_q;
  logic [RANKS-1:0][DATA_W-1:0] slot_d;

  for (genvar g = 0; g < RANKS; g++) begin : g_slot
    assign beats[g] = sample > slot_q[g];
    if (g == 0) begin : g_head
      assign slot_d[g] = sample;
    end else begin : g_tail
      assign slot_d[g] = shift_sel[g] ? slot_q[g-1] : sample;
    end

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        slot_q[g] <= '0;
      end else if (slot_en[g]) begin
        slot_q[g] <= slot_d[g];
      end
    end
  end

  assign ranks = slot_q;
endmodule

// File: rtl/rank3_accum.sv
module rank3_accum #(
  parameter int DATA_W = 8,
  parameter int LOG_K  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     take,
  input  logic [DATA_W-1:0]        sample,
  output logic                     last,
  output logic [DATA_W+LOG_K-1:0]  sum
);
  localparam int SUM_W = DATA_W + LOG_K;

  logic [SUM_W-1:0] sum_q;
  logic [LOG_K-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      sum_q <= sum_q + SUM_W'(sample);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == {LOG_K{1'b1}});
  assign sum  = sum_q;
endmodule

// File: rtl/rank3_ctrl.sv
module rank3_ctrl
  import rank3_mean_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             last,
  input  logic [RANKS-1:0] beats,
  output logic             clr,
  output logic             run,
  output logic [RANKS-1:0] slot_en,
  output logic [RANKS-1:0] shift_sel,
  output logic             finished
);
  run_state_t state_q, state_d;
  logic       fin_q;

  assign run = (state_q == ST_RUN);
  assign clr = start && !run;

  always_comb begin
    slot_en      = beats & {RANKS{run}};
    shift_sel[0] = 1'b0;
    for (int i = 1; i < RANKS; i++) begin
      shift_sel[i] = beats[i-1];
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_RUN;
      ST_RUN:  if (last)  state_d = ST_FIN;
      ST_FIN:  if (start) state_d = ST_RUN;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fin_q   <= (state_q == ST_FIN) && !start;
    end
  end

  assign finished = fin_q;
endmodule

// File: rtl/rank3_mean.sv
module rank3_mean
  import rank3_mean_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOG_K  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] sample,
  input  logic [1:0]        sel_mode,
  output logic [DATA_W-1:0] result,
  output logic              finished
);
  localparam int SUM_W = DATA_W + LOG_K;

  logic                         clr;
  logic                         run;
  logic                         last;
  logic [RANKS-1:0]             beats;
  logic [RANKS-1:0]             slot_en;
  logic [RANKS-1:0]             shift_sel;
  logic [RANKS-1:0][DATA_W-1:0] ranks;
  logic [SUM_W-1:0]             sum;
  logic [DATA_W-1:0]            mean;
  logic [DATA_W-1:0]            pick;
  logic [DATA_W-1:0]            result_q;

  rank3_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .last      (last),
    .beats     (beats),
    .clr       (clr),
    .run       (run),
    .slot_en   (slot_en),
    .shift_sel (shift_sel),
    .finished  (finished)
  );

  rank3_list #(.DATA_W(DATA_W)) u_list (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .sample    (sample),
    .slot_en   (slot_en),
    .shift_sel (shift_sel),
    .beats     (beats),
    .ranks     (ranks)
  );

  rank3_accum #(.DATA_W(DATA_W), .LOG_K(LOG_K)) u_accum (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .take   (run),
    .sample (sample),
    .last   (last),
    .sum    (sum)
  );

  assign mean = DATA_W'(sum >> LOG_K);

  always_comb begin
    if (sel_mode == SEL_MEAN) begin
      pick = mean;
    end else begin
      pick = ranks[RANKS - int'(sel_mode)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
    end else begin
      result_q <= pick;
    end
  end

  assign result = result_q;
endmodule

// File: rtl/rank3_mean_chk.sv
module rank3_mean_chk
  import rank3_mean_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOG_K  = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         start,
  input logic                         finished,
  input logic                         busy,
  input logic                         last,
  input logic [DATA_W+LOG_K-1:0]      sum,
  input logic [RANKS-1:0][DATA_W-1:0] ranks
);
  p_sorted_r3: assert property (@(posedge clk) disable iff (rst)
    (ranks[0] >= ranks[1]) && (ranks[1] >= ranks[2]));

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (sum == '0 && ranks == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (sum >= $past(sum)));

  p_top_grows_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> (ranks[0] >= $past(ranks[0])));

  p_done_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (finished && !start) |=> finished);

  p_done_timing_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(finished) |-> $past(busy && last, 2));

  p_go_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !last && start) |=> busy);
endmodule

bind rank3_mean rank3_mean_chk #(.DATA_W(DATA_W), .LOG_K(LOG_K)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .finished (finished),
  .busy     (run),
  .last     (last),
  .sum      (sum),
  .ranks    (ranks)
);

// File: tb/tb_rank3_mean.sv
module tb_rank3_mean;
  localparam int DW = 3;
  localparam int LK = 2;
  localparam int K  = 1 << LK;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] sample = '0;
  logic [1:0]    sel_mode = 2'b00;
  logic [DW-1:0] result;
  logic          finished;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  ended   = 1'b0;

  rank3_mean #(.DATA_W(DW), .LOG_K(LK)) dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sample   (sample),
    .sel_mode (sel_mode),
    .result   (result),
    .finished (finished)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Full run of K=4 samples; optional stray start in the middle (R11).
  task automatic run_seq(input int a, input int b, input int c, input int d,
                         input bit stray);
    int s[4];
    int srt[4];
    int tot;
    s = '{a, b, c, d};
    tot = 0;
    for (int i = 0; i < 4; i++) begin
      srt[i] = s[i];
      tot += s[i];
    end
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 3 - i; j++) begin
        if (srt[j] < srt[j+1]) begin
          int t;
          t = srt[j]; srt[j] = srt[j+1]; srt[j+1] = t;
        end
      end
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; sample = DW'(s[0]);
    for (int i = 1; i < K; i++) begin
      @(negedge clk);
      sample = DW'(s[i]);
      start  = stray && (i == 2);
    end
    @(negedge clk); start = 1'b0; sample = '0;
    chk("R10", int'(finished), 0);
    sel_mode = 2'b00;
    @(negedge clk);
    chk(stray ? "R11" : "R10", int'(finished), 1);
    chk(stray ? "R11" : "R8", int'(result), tot >> LK);
    sel_mode = 2'b01;
    @(negedge clk);
    chk(stray ? "R11" : "R5", int'(result), srt[2]);
    sel_mode = 2'b10;
    @(negedge clk);
    chk(stray ? "R11" : "R4", int'(result), srt[1]);
    sel_mode = 2'b11;
    @(negedge clk);
    chk(stray ? "R11" : "R3", int'(result), srt[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(finished), 0);
    chk("R1", int'(result), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", int'(finished), 0);
    chk("R1", int'(result), 0);

    // Exhaustive sweep over every 4-sample sequence of 3-bit values.
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++)
          for (int d = 0; d < 8; d++)
            run_seq(a, b, c, d, 1'b0);

    // R10: finished holds while idle, then clears on the start edge.
    repeat (3) @(negedge clk);
    chk("R10", int'(finished), 1);
    // R6: last sample below third and ties leave list unchanged.
    run_seq(6, 5, 4, 1, 1'b0);
    sel_mode = 2'b01; @(negedge clk);
    chk("R6", int'(result), 4);
    run_seq(5, 5, 5, 5, 1'b0);
    sel_mode = 2'b01; @(negedge clk);
    chk("R6", int'(result), 5);

    // R7: all-maximum run, mean equals maximum.
    run_seq(7, 7, 7, 7, 1'b0);
    sel_mode = 2'b00; @(negedge clk); @(negedge clk);
    chk("R7", int'(result), 7);

    // R2: a zero run after a large run must show all zeros.
    run_seq(0, 0, 0, 0, 1'b0);
    sel_mode = 2'b11; @(negedge clk);
    chk("R2", int'(result), 0);
    sel_mode = 2'b00; @(negedge clk); @(negedge clk);
    chk("R2", int'(result), 0);

    // R9: result follows sel_mode exactly one edge later.
    run_seq(3, 6, 2, 1, 1'b0);
    sel_mode = 2'b10; @(negedge clk);
    chk("R9", int'(result), 3);
    sel_mode = 2'b00; @(negedge clk);
    chk("R9", int'(result), 3);

    // R11: stray start while samples are being consumed.
    run_seq(2, 7, 1, 4, 1'b1);
    run_seq(7, 0, 6, 3, 1'b1);

    // R10: start from finished clears finished on that edge.
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10", int'(finished), 0);
    repeat (K + 1) @(negedge clk);
    chk("R10", int'(finished), 1);

    finish_run();
  end
endmodule